// File: doc/BRIEF.md
# Single-Precision Compare Unit with Sticky Status

This block compares two IEEE-754 single-precision operands under one of seven conditions. It returns the one-bit answer zero-extended to a 32-bit word, one clock after the operands are presented. The conditions do not all use the same operand order. The ones that order their operands treat every NaN as an invalid operation. Equality, inequality and the unordered test raise invalid only for a signalling NaN.

The unit also owns a sticky floating-point status register with four flags: invalid, divide-by-zero, overflow and underflow. A compare can set only the invalid flag. A neighbouring arithmetic unit posts its four raw flags through a separate port, and those posts can set any of the flags. Software clears flags with a bit mask. When an operation raises any flag while both the floating-point trap configuration bit and the global exception enable are set, the unit pulses an exception request for one cycle.

Top module: `fcmp_unit`

## Requirements
- R1: `resValid` rises exactly one cycle after each cycle with `opValid` high. In that cycle `result` holds the answer in bit 0, with bits 31:1 zero. `result` keeps its value until the next accepted compare. Condition code 7 returns 0 and raises no flag.
- R2: The ordered conditions use these codes and operand orders: code 1 returns b < a, code 4 returns a < b, code 3 returns a ≤ b, and code 6 returns NOT(a < b). Codes 1, 3 and 4 return 0 when either operand is NaN. Code 6 returns 1 in that case.
- R3: Code 2 (equal) returns 1 when the operands are numerically equal. Code 5 (not-equal) is always its inverse, so it returns 1 when either operand is NaN. +0 and −0 compare equal.
- R4: Code 0 (unordered) returns 1 exactly when at least one operand is NaN.
- R5: A NaN has an all-ones exponent (bits 30:23) and a nonzero fraction (bits 22:0). It is signalling when bit 22 is 0. Codes 1, 3, 4 and 6 raise invalid for any NaN operand. Codes 0, 2 and 5 raise invalid only for a signalling NaN.
- R6: Non-NaN operands are ordered by sign and magnitude. Negative values order below positive values, and a larger magnitude orders lower among negatives. Infinities are the extremes.
- R7: `status` bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, and bit 0 reads 0. A compare changes only bit 4.
- R8: When `flagPostValid` is high, `flagPost` bit 3 (invalid), bit 2 (divide-by-zero), bit 1 (overflow) and bit 0 (underflow) are ORed into status bits 4, 3, 2 and 1. Every set bit stays set until it is cleared.
- R9: When `statusClrEn` is high, each status flag whose `statusClr` bit is 1 is cleared. The mask uses the same bit order as `flagPost`. A flag raised in the same cycle wins over its clear.
- R10: `excReq` is high for exactly the cycle after an operation that raised at least one flag, and only if `trapCfgEn` and `globalExcEn` were both high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Accept a compare this cycle |
| opA | input | 32 | Operand a |
| opB | input | 32 | Operand b |
| cond | input | 3 | Condition code (0..6, 7 reserved) |
| flagPostValid | input | 1 | External flag post strobe |
| flagPost | input | 4 | Posted flags {invalid, div-zero, overflow, underflow} |
| statusClrEn | input | 1 | Apply clear mask this cycle |
| statusClr | input | 4 | Clear mask, same order as flagPost |
| trapCfgEn | input | 1 | Floating-point trap configuration bit |
| globalExcEn | input | 1 | Global exception enable |
| resValid | output | 1 | Result valid |
| result | output | 32 | Compare answer, zero-extended |
| status | output | 5 | Sticky status flags |
| excReq | output | 1 | One-cycle exception request |

## Verification
The hardest cases to reach are the ones where several things happen in the same cycle: a compare raising invalid while the same flag is being cleared, and a flag post and a clear landing on the same edge. The stimulus sweeps every ordered pair from a set of signed zeros, ±1, ±2, infinity, a quiet NaN and a signalling NaN through all eight condition codes. Each compare in that sweep carries a full clear, so the status after each compare shows only the invalid flag that compare raised. Directed sequences then interleave posts, partial clears and enable combinations, and they re-raise an already-set flag to show that the exception request depends on the raise, not on the stored state.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [2:0] {
    CMP_UNORD = 3'd0,
    CMP_LT    = 3'd1,
    CMP_EQ    = 3'd2,
    CMP_LE    = 3'd3,
    CMP_GT    = 3'd4,
    CMP_NE    = 3'd5,
    CMP_GE    = 3'd6,
    CMP_NONE  = 3'd7
  } cmp_cond_e;

  typedef struct packed {
    logic capture;
    logic selUnord;
    logic selLt;
    logic selEq;
    logic selLe;
    logic selGt;
    logic selNe;
    logic selGe;
  } cmp_strobe_t;
endpackage

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [EXP_W+FRAC_W:0]         opA,
  input  logic [EXP_W+FRAC_W:0]         opB,
  input  cmp_strobe_t                   stb,
  output logic                          anyNaN,
  output logic                          anySnan,
  output logic [EXP_W+FRAC_W:0]         result
);
  localparam int W   = 1 + EXP_W + FRAC_W;
  localparam int MAG = W - 1;

  logic nanA, nanB, snanA, snanB;
  logic signA, signB, zeroBoth;
  logic magLtAB, magLtBA;
  logic ltAB, ltBA, eqAB, ordered;
  logic cmpBit, cmpReg;

  always_comb begin
    nanA  = (&opA[MAG-1:FRAC_W]) && (|opA[FRAC_W-1:0]);
    nanB  = (&opB[MAG-1:FRAC_W]) && (|opB[FRAC_W-1:0]);
    snanA = nanA && !opA[FRAC_W-1];
    snanB = nanB && !opB[FRAC_W-1];
    anyNaN  = nanA || nanB;
    anySnan = snanA || snanB;
    ordered = !anyNaN;

    signA    = opA[W-1];
    signB    = opB[W-1];
    zeroBoth = (~|opA[MAG-1:0]) && (~|opB[MAG-1:0]);
    magLtAB  = opA[MAG-1:0] < opB[MAG-1:0];
    magLtBA  = opB[MAG-1:0] < opA[MAG-1:0];

    if (zeroBoth)            ltAB = 1'b0;
    else if (signA != signB) ltAB = signA;
    else if (!signA)         ltAB = magLtAB;
    else                     ltAB = magLtBA;

    if (zeroBoth)            ltBA = 1'b0;
    else if (signA != signB) ltBA = signB;
    else if (!signB)         ltBA = magLtBA;
    else                     ltBA = magLtAB;

    eqAB = zeroBoth || (opA == opB);

    cmpBit = (stb.selUnord & anyNaN)
           | (stb.selLt    & ordered & ltBA)
           | (stb.selEq    & ordered & eqAB)
           | (stb.selLe    & ordered & (ltAB | eqAB))
           | (stb.selGt    & ordered & ltAB)
           | (stb.selNe    & !(ordered & eqAB))
           | (stb.selGe    & !(ordered & ltAB));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cmpReg <= 1'b0;
    else if (stb.capture) cmpReg <= cmpBit;
  end

  assign result = {{(W-1){1'b0}}, cmpReg};
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
#(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       cond,
  input  logic             anyNaN,
  input  logic             anySnan,
  input  logic             flagPostValid,
  input  logic [NFLAG-1:0] flagPost,
  input  logic             statusClrEn,
  input  logic [NFLAG-1:0] statusClr,
  input  logic             trapCfgEn,
  input  logic             globalExcEn,
  output cmp_strobe_t      stb,
  output logic             resValid,
  output logic [NFLAG:0]   status,
  output logic             excReq
);
  localparam int INV_BIT = NFLAG - 1;

  logic [NFLAG-1:0] flags, raised, clrMask;
  logic             invRaise, orderedSel, quietSel;
  cmp_cond_e        condE;

  always_comb begin
    condE = cmp_cond_e'(cond);
    stb = '0;
    stb.capture = opValid;
    unique case (condE)
      CMP_UNORD: stb.selUnord = 1'b1;
      CMP_LT:    stb.selLt    = 1'b1;
      CMP_EQ:    stb.selEq    = 1'b1;
      CMP_LE:    stb.selLe    = 1'b1;
      CMP_GT:    stb.selGt    = 1'b1;
      CMP_NE:    stb.selNe    = 1'b1;
      CMP_GE:    stb.selGe    = 1'b1;
      CMP_NONE:  ;
    endcase
    orderedSel = stb.selLt | stb.selLe | stb.selGt | stb.selGe;
    quietSel   = stb.selUnord | stb.selEq | stb.selNe;
    invRaise   = opValid & ((orderedSel & anyNaN) | (quietSel & anySnan));
    raised     = (flagPostValid ? flagPost : '0);
    raised[INV_BIT] = raised[INV_BIT] | invRaise;
    clrMask    = statusClrEn ? statusClr : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags    <= '0;
      resValid <= 1'b0;
      excReq   <= 1'b0;
    end else begin
      flags    <= (flags & ~clrMask) | raised;
      resValid <= opValid;
      excReq   <= (|raised) & trapCfgEn & globalExcEn;
    end
  end

  assign status = {flags, 1'b0};
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int NFLAG  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic [2:0]            cond,
  input  logic                  flagPostValid,
  input  logic [NFLAG-1:0]      flagPost,
  input  logic                  statusClrEn,
  input  logic [NFLAG-1:0]      statusClr,
  input  logic                  trapCfgEn,
  input  logic                  globalExcEn,
  output logic                  resValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic [NFLAG:0]        status,
  output logic                  excReq
);
  cmp_strobe_t stb;
  logic        anyNaN, anySnan;

  fcmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .stb(stb),
    .anyNaN(anyNaN), .anySnan(anySnan), .result(result)
  );

  fcmp_ctrl #(.NFLAG(NFLAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .cond(cond),
    .anyNaN(anyNaN), .anySnan(anySnan),
    .flagPostValid(flagPostValid), .flagPost(flagPost),
    .statusClrEn(statusClrEn), .statusClr(statusClr),
    .trapCfgEn(trapCfgEn), .globalExcEn(globalExcEn),
    .stb(stb), .resValid(resValid), .status(status), .excReq(excReq)
  );
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk #(
  parameter int W     = 32,
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             flagPostValid,
  input logic [NFLAG-1:0] flagPost,
  input logic             statusClrEn,
  input logic             trapCfgEn,
  input logic             globalExcEn,
  input logic             resValid,
  input logic [W-1:0]     result,
  input logic [NFLAG:0]   status,
  input logic             excReq
);
  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid); // R1
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(result))); // R1
  AST_CMP_ONLY_INV: assert property (@(posedge clk) disable iff (!rstN)
    (!flagPostValid && !statusClrEn) |=> (status[NFLAG-1:0] == $past(status[NFLAG-1:0]))); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !statusClrEn |=> ((status & $past(status)) == $past(status))); // R8
  AST_POST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    flagPostValid |=> ((status[NFLAG:1] & $past(flagPost)) == $past(flagPost))); // R9
  AST_EXC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(trapCfgEn && globalExcEn)); // R10
endmodule

bind fcmp_unit fcmp_unit_chk #(.W(1 + EXP_W + FRAC_W), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .flagPostValid(flagPostValid),
  .flagPost(flagPost), .statusClrEn(statusClrEn), .trapCfgEn(trapCfgEn),
  .globalExcEn(globalExcEn), .resValid(resValid), .result(result),
  .status(status), .excReq(excReq)
);

// File: tb/fcmp_unit_tb.sv
module fcmp_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  cond = '0;
  logic        flagPostValid = 1'b0;
  logic [3:0]  flagPost = '0;
  logic        statusClrEn = 1'b0;
  logic [3:0]  statusClr = '0;
  logic        trapCfgEn = 1'b0, globalExcEn = 1'b0;
  logic        resValid, excReq;
  logic [31:0] result;
  logic [4:0]  status;

  int nChecks = 0, nFails = 0;
  logic [4:0] shStat = '0;

  typedef struct { logic res; logic [4:0] stat; logic exc; string tag; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  fcmp_unit u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opA(opA), .opB(opB), .cond(cond),
    .flagPostValid(flagPostValid), .flagPost(flagPost), .statusClrEn(statusClrEn),
    .statusClr(statusClr), .trapCfgEn(trapCfgEn), .globalExcEn(globalExcEn),
    .resValid(resValid), .result(result), .status(status), .excReq(excReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic isNan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic signed [33:0] key(input logic [31:0] x);
    logic signed [33:0] m;
    m = $signed({3'b000, x[30:0]});
    return x[31] ? -m : m;
  endfunction

  // Reference model from R2..R5: returns answer and invalid raise
  function automatic logic [1:0] model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
    logic nan, snan, lt, gtb, eq, r, inv;
    nan  = isNan(a) || isNan(b);
    snan = (isNan(a) && !a[22]) || (isNan(b) && !b[22]);
    lt   = !nan && (key(a) < key(b));
    gtb  = !nan && (key(b) < key(a));
    eq   = !nan && (key(a) == key(b));
    r = 1'b0; inv = 1'b0;
    case (c)
      3'd0: begin r = nan;       inv = snan; end
      3'd1: begin r = gtb;       inv = nan;  end
      3'd2: begin r = eq;        inv = snan; end
      3'd3: begin r = lt || eq;  inv = nan;  end
      3'd4: begin r = lt;        inv = nan;  end
      3'd5: begin r = !eq;       inv = snan; end
      3'd6: begin r = !lt;       inv = nan;  end
      default: begin r = 1'b0;   inv = 1'b0; end
    endcase
    return {r, inv};
  endfunction

  // Driver: one compare, optional clear mask in the same cycle
  task automatic doOp(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c,
                      input logic clrEn, input logic [3:0] clr, input string tag);
    logic [1:0] m;
    item_t it;
    @(negedge clk);
    opA = a; opB = b; cond = c; opValid = 1'b1;
    statusClrEn = clrEn; statusClr = clr;
    m = model(a, b, c);
    shStat = (shStat & ~(clrEn ? {clr, 1'b0} : 5'b0)) | {m[0], 4'b0};
    it.res = m[1]; it.stat = shStat; it.exc = m[0] & trapCfgEn & globalExcEn; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    opValid = 1'b0; statusClrEn = 1'b0; statusClr = '0;
  endtask

  // Monitor: scoreboard compare when a result appears
  always @(negedge clk) begin
    if (rstN && resValid) begin
      item_t it;
      if (sbq.size() == 0) begin
        check("R1 unexpected resValid", 32'd1, 32'd0);
      end else begin
        it = sbq.pop_front();
        check({it.tag, " R1/R2/R3/R4/R6 result"}, result, {31'b0, it.res});
        check({it.tag, " R5/R7 status"}, {27'b0, status}, {27'b0, it.stat});
        check({it.tag, " R10 excReq"}, {31'b0, excReq}, {31'b0, it.exc});
      end
    end
  end

  task automatic post(input logic [3:0] f, input logic clrEn, input logic [3:0] clr,
                      input logic expExc, input string tag);
    @(negedge clk);
    flagPostValid = 1'b1; flagPost = f; statusClrEn = clrEn; statusClr = clr;
    shStat = (shStat & ~(clrEn ? {clr, 1'b0} : 5'b0)) | {f, 1'b0};
    @(negedge clk);
    flagPostValid = 1'b0; flagPost = '0; statusClrEn = 1'b0; statusClr = '0;
    check({tag, " status"}, {27'b0, status}, {27'b0, shStat});
    check({tag, " R10 excReq"}, {31'b0, excReq}, {31'b0, expExc});
    @(negedge clk);
    check({tag, " R10 excReq pulse ends"}, {31'b0, excReq}, 32'd0);
  endtask

  initial begin
    automatic int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    check("watchdog expired", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] vals [9];
    vals = '{32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
             32'h4000_0000, 32'hC000_0000, 32'h7F80_0000, 32'h7FC0_0000, 32'h7F80_0001};
    repeat (3) @(negedge clk);
    check("R1 reset resValid", {31'b0, resValid}, 32'd0);
    check("R7 reset status", {27'b0, status}, 32'd0);
    check("R10 reset excReq", {31'b0, excReq}, 32'd0);
    rstN = 1'b1;

    // Sweep: every pair, every code; full clear in the same cycle (R9 set-wins)
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int c = 0; c < 8; c++)
          doOp(vals[i], vals[j], 3'(c), 1'b1, 4'hF, $sformatf("sweep a=%h b=%h c=%0d", vals[i], vals[j], c));
    @(negedge clk);

    // R9 clear all, R8 sticky posts
    post(4'b0000, 1'b1, 4'hF, 1'b0, "R9 clear all");
    post(4'b0100, 1'b0, 4'h0, 1'b0, "R8 post divzero");
    post(4'b0001, 1'b0, 4'h0, 1'b0, "R8 post underflow sticky");
    // R7: compare raises invalid only, other bits kept
    doOp(32'h7FC0_0000, 32'h3F80_0000, 3'd1, 1'b0, 4'h0, "R7 lt quiet NaN");
    @(negedge clk);
    check("R7 status after compare", {27'b0, status}, 32'h1A);
    // R9 partial clear of divide-by-zero
    post(4'b0000, 1'b1, 4'b0100, 1'b0, "R9 partial clear");
    // R10 config alone does not request
    trapCfgEn = 1'b1;
    post(4'b0010, 1'b0, 4'h0, 1'b0, "R10 cfg only");
    globalExcEn = 1'b1;
    doOp(32'h3F80_0000, 32'h3F80_0000, 3'd2, 1'b0, 4'h0, "R10 no flag no request");
    doOp(32'h7F80_0001, 32'h0000_0000, 3'd5, 1'b0, 4'h0, "R10 ne signalling NaN request");
    @(negedge clk);
    post(4'b0001, 1'b0, 4'h0, 1'b1, "R10 re-raise set flag");
    globalExcEn = 1'b0;
    post(4'b1000, 1'b0, 4'h0, 1'b0, "R10 global off");
    // R9 clear and post same edge: post wins
    post(4'b1000, 1'b1, 4'hF, 1'b0, "R9 post wins over clear");
    check("R9 final status", {27'b0, status}, 32'h10);

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", sbq.size(), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule